// File: doc/BRIEF.md
# Reorder Buffer Head Commit Decision Unit

This block sits at the retirement end of an out-of-order core. Each cycle it looks at up to `WIDTH` consecutive entries at the head of the reorder buffer, in age order. For each one it decides whether the entry leaves the buffer, waits, goes back for non-speculative execution, is replayed as an uncached load, raises a trap or is flagged as malformed. The scan ends at the first entry that cannot leave. Entries after that point are left alone until a later cycle.

The reorder buffer presents each head entry with a valid bit, a sequence number, the address of the following instruction and a ten-bit attribute word. The unit returns a retire mask, which the buffer uses to pop entries, and a completion mask for non-store entries. It also returns the committed count for the cycle, one request pulse with the sequence number it concerns, and the architectural position: the youngest committed sequence number and the next instruction address. A raised trap blocks all retirement until the trap handler releases the thread. All outputs are registered.

Top module: `rob_commit_decide`

## Requirements
- R1: Attribute bits per slot are: bit 0 executed, 1 squashed, 2 non-speculative, 3 store-conditional, 4 memory barrier, 5 write barrier, 6 quiesce, 7 load, 8 store, 9 fault. Slot 0 is the oldest. Slots are scanned in order, and the scan stops at the first slot that is not valid or cannot leave, so `retire_o` is always a contiguous run from slot 0.
- R2: A valid squashed entry leaves the buffer (its `retire_o` bit is set) but does not add to `count_o`, and the scan continues past it.
- R3: An unexecuted entry with the non-speculative, store-conditional, memory-barrier or write-barrier attribute is held with no request in two cases. The first is when it is a memory barrier, write barrier or quiesce and stores are pending writeback. The second is when an entry has already committed earlier in the same cycle. Otherwise it raises `nspec_req_o` with its sequence number on `req_seq_o`, and nothing after it retires.
- R4: An unexecuted load outside the R3 group raises `uncached_req_o` with its sequence number, in any slot position, and ends the scan.
- R5: An executed entry with the fault attribute waits, silently, while stores are pending or after an earlier commit in the same cycle. Otherwise it raises `trap_req_o` with its sequence number and sets `trap_pend_o`.
- R6: While `trap_pend_o` is high, nothing retires or commits, whatever the head entries are. Asserting `trap_clear_i` clears `trap_pend_o` at the next edge, and retirement resumes in the cycle after that.
- R7: When at least one entry commits, `done_seq_o` and `pc_o` take the sequence number and next-instruction address of the youngest committed entry. Otherwise both hold their values.
- R8: `complete_o` marks the committed entries that are not stores. Squashed and store entries are never marked.
- R9: `bw_limit_o` is high exactly when `count_o` equals `WIDTH`.
- R10: An unexecuted entry that is neither in the R3 group nor a load raises `err_o` with its sequence number and ends the scan.
- R11: After reset, all outputs are zero.
- R12: Every output reflects the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stores_pend_i | input | 1 | Stores are still waiting for writeback |
| trap_clear_i | input | 1 | Trap handler done; release the thread |
| head_vld_i | input | WIDTH | Head entry present and ready, per slot |
| head_flags_i | input | WIDTH*10 | Attribute words, slot 0 in the low bits |
| head_seq_i | input | WIDTH*SEQW | Sequence numbers, slot 0 in the low bits |
| head_npc_i | input | WIDTH*PCW | Next-instruction addresses, slot 0 in the low bits |
| retire_o | output | WIDTH | Entries removed from the buffer |
| complete_o | output | WIDTH | Committed non-store entries |
| count_o | output | clog2(WIDTH+1) | Entries committed this cycle |
| bw_limit_o | output | 1 | Cycle used the full commit width |
| nspec_req_o | output | 1 | Non-speculative execution request |
| uncached_req_o | output | 1 | Uncached load replay request |
| trap_req_o | output | 1 | Trap request |
| err_o | output | 1 | Unexecuted entry of unsupported type |
| req_seq_o | output | SEQW | Sequence number for the request pulse |
| done_seq_o | output | SEQW | Youngest committed sequence number |
| pc_o | output | PCW | Next instruction address after last commit |
| trap_pend_o | output | 1 | Trap outstanding; retirement blocked |

## Verification
Two functions can occur in the same cycle: a squashed entry is dropped and the entry behind it is sent back as a non-speculative request or a trap. The slot-zero rule counts commits, not slots, so the dropped entry must not stop the request. The bench provokes this with a squashed entry in slot 0 and a barrier or faulting entry in slot 1. It expects the retire mask to hold only slot 0 and the count to be zero, and it expects the request to carry the slot-1 sequence number. It also drives the opposite case, a committed entry ahead of the barrier, and expects the barrier to be held with no request.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Attribute word layout for one head entry.
    localparam int unsigned FLAG_N    = 10;
    localparam int unsigned FB_EXEC   = 0;
    localparam int unsigned FB_SQSH   = 1;
    localparam int unsigned FB_NSPEC  = 2;
    localparam int unsigned FB_STCOND = 3;
    localparam int unsigned FB_MBAR   = 4;
    localparam int unsigned FB_WBAR   = 5;
    localparam int unsigned FB_QUIES  = 6;
    localparam int unsigned FB_LOAD   = 7;
    localparam int unsigned FB_STORE  = 8;
    localparam int unsigned FB_FAULT  = 9;

    // Per-slot verdict, before the position rule is applied.
    typedef enum logic [2:0] {
        ACT_HOLD     = 3'd0,
        ACT_DROP     = 3'd1,
        ACT_RETIRE   = 3'd2,
        ACT_NSPEC    = 3'd3,
        ACT_UNCACHED = 3'd4,
        ACT_TRAP     = 3'd5,
        ACT_BAD      = 3'd6
    } slot_act_e;

endpackage

// File: rtl/cmt_slot_eval.sv
module cmt_slot_eval
    import cmt_pkg::*;
(
    input  logic              vld_i,
    input  logic [FLAG_N-1:0] flags_i,
    input  logic              stores_pend_i,
    output slot_act_e         act_o
);

    logic ordered;
    logic drain_wait;

    always_comb begin
        ordered    = flags_i[FB_NSPEC] | flags_i[FB_STCOND] |
                     flags_i[FB_MBAR]  | flags_i[FB_WBAR];
        drain_wait = (flags_i[FB_MBAR] | flags_i[FB_WBAR] | flags_i[FB_QUIES]) &
                     stores_pend_i;
        act_o      = ACT_HOLD;
        if (!vld_i) begin
            act_o = ACT_HOLD;
        end else if (flags_i[FB_SQSH]) begin
            act_o = ACT_DROP;
        end else if (!flags_i[FB_EXEC]) begin
            if (ordered) begin
                act_o = drain_wait ? ACT_HOLD : ACT_NSPEC;
            end else if (flags_i[FB_LOAD]) begin
                act_o = ACT_UNCACHED;
            end else begin
                act_o = ACT_BAD;
            end
        end else if (flags_i[FB_FAULT]) begin
            act_o = stores_pend_i ? ACT_HOLD : ACT_TRAP;
        end else begin
            act_o = ACT_RETIRE;
        end
    end

endmodule

// File: rtl/cmt_field_mux.sv
module cmt_field_mux #(
    parameter int unsigned N    = 4,
    parameter int unsigned DW   = 16,
    parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*DW-1:0] bus_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [DW-1:0]   val_o
);

    always_comb begin
        val_o = '0;
        for (int i = 0; i < N; i++) begin
            if (idx_i == IDXW'(i)) begin
                val_o = bus_i[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/cmt_scan.sv
module cmt_scan
    import cmt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned CNTW  = $clog2(WIDTH + 1),
    parameter int unsigned IDXW  = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic                    enable_i,
    input  logic                    stores_pend_i,
    input  logic [WIDTH-1:0]        vld_i,
    input  logic [WIDTH*FLAG_N-1:0] flags_i,
    output logic [WIDTH-1:0]        retire_o,
    output logic [WIDTH-1:0]        complete_o,
    output logic [CNTW-1:0]         count_o,
    output logic                    halt_o,
    output slot_act_e               halt_act_o,
    output logic [IDXW-1:0]         halt_idx_o,
    output logic [IDXW-1:0]         last_idx_o
);

    slot_act_e slot_act [WIDTH];

    for (genvar g = 0; g < WIDTH; g++) begin : g_slot
        cmt_slot_eval u_eval (
            .vld_i         (vld_i[g]),
            .flags_i       (flags_i[g*FLAG_N +: FLAG_N]),
            .stores_pend_i (stores_pend_i),
            .act_o         (slot_act[g])
        );
    end

    // Serial walk: ordered requests and traps need commit position zero.
    always_comb begin
        logic      live;
        slot_act_e eff;
        live       = enable_i;
        eff        = ACT_HOLD;
        retire_o   = '0;
        complete_o = '0;
        count_o    = '0;
        halt_o     = 1'b0;
        halt_act_o = ACT_HOLD;
        halt_idx_o = '0;
        last_idx_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            eff = slot_act[i];
            if ((eff == ACT_NSPEC || eff == ACT_TRAP) && count_o != '0) begin
                eff = ACT_HOLD;
            end
            if (live) begin
                case (eff)
                    ACT_RETIRE: begin
                        retire_o[i]   = 1'b1;
                        complete_o[i] = ~flags_i[i*FLAG_N + FB_STORE];
                        count_o       = count_o + CNTW'(1);
                        last_idx_o    = IDXW'(i);
                    end
                    ACT_DROP: begin
                        retire_o[i] = 1'b1;
                    end
                    ACT_HOLD: begin
                        live = 1'b0;
                    end
                    default: begin
                        live       = 1'b0;
                        halt_o     = 1'b1;
                        halt_act_o = eff;
                        halt_idx_o = IDXW'(i);
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/rob_commit_decide.sv
module rob_commit_decide
    import cmt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned SEQW  = 16,
    parameter int unsigned PCW   = 32
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           stores_pend_i,
    input  logic                           trap_clear_i,
    input  logic [WIDTH-1:0]               head_vld_i,
    input  logic [WIDTH*10-1:0]            head_flags_i,
    input  logic [WIDTH*SEQW-1:0]          head_seq_i,
    input  logic [WIDTH*PCW-1:0]           head_npc_i,
    output logic [WIDTH-1:0]               retire_o,
    output logic [WIDTH-1:0]               complete_o,
    output logic [$clog2(WIDTH+1)-1:0]     count_o,
    output logic                           bw_limit_o,
    output logic                           nspec_req_o,
    output logic                           uncached_req_o,
    output logic                           trap_req_o,
    output logic                           err_o,
    output logic [SEQW-1:0]                req_seq_o,
    output logic [SEQW-1:0]                done_seq_o,
    output logic [PCW-1:0]                 pc_o,
    output logic                           trap_pend_o
);

    localparam int unsigned CNTW = $clog2(WIDTH + 1);
    localparam int unsigned IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    typedef struct packed {
        logic [WIDTH-1:0] retire;
        logic [WIDTH-1:0] complete;
        logic [CNTW-1:0]  count;
        logic             bw_limit;
        logic             nspec;
        logic             uncached;
        logic             trap;
        logic             err;
        logic [SEQW-1:0]  req_seq;
        logic [SEQW-1:0]  done_seq;
        logic [PCW-1:0]   pc;
        logic             trap_pend;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [WIDTH-1:0] scan_retire;
    logic [WIDTH-1:0] scan_complete;
    logic [CNTW-1:0]  scan_count;
    logic             scan_halt;
    slot_act_e        scan_act;
    logic [IDXW-1:0]  halt_idx;
    logic [IDXW-1:0]  last_idx;
    logic [SEQW-1:0]  halt_seq;
    logic [SEQW-1:0]  last_seq;
    logic [PCW-1:0]   last_npc;

    cmt_scan #(
        .WIDTH (WIDTH),
        .CNTW  (CNTW),
        .IDXW  (IDXW)
    ) u_scan (
        .enable_i      (~st_q.trap_pend),
        .stores_pend_i (stores_pend_i),
        .vld_i         (head_vld_i),
        .flags_i       (head_flags_i),
        .retire_o      (scan_retire),
        .complete_o    (scan_complete),
        .count_o       (scan_count),
        .halt_o        (scan_halt),
        .halt_act_o    (scan_act),
        .halt_idx_o    (halt_idx),
        .last_idx_o    (last_idx)
    );

    cmt_field_mux #(.N(WIDTH), .DW(SEQW), .IDXW(IDXW)) u_halt_seq (
        .bus_i (head_seq_i),
        .idx_i (halt_idx),
        .val_o (halt_seq)
    );

    cmt_field_mux #(.N(WIDTH), .DW(SEQW), .IDXW(IDXW)) u_last_seq (
        .bus_i (head_seq_i),
        .idx_i (last_idx),
        .val_o (last_seq)
    );

    cmt_field_mux #(.N(WIDTH), .DW(PCW), .IDXW(IDXW)) u_last_npc (
        .bus_i (head_npc_i),
        .idx_i (last_idx),
        .val_o (last_npc)
    );

    always_comb begin
        st_d          = st_q;
        st_d.retire   = scan_retire;
        st_d.complete = scan_complete;
        st_d.count    = scan_count;
        st_d.bw_limit = (scan_count == CNTW'(WIDTH));
        st_d.nspec    = 1'b0;
        st_d.uncached = 1'b0;
        st_d.trap     = 1'b0;
        st_d.err      = 1'b0;
        if (scan_halt) begin
            st_d.req_seq = halt_seq;
            case (scan_act)
                ACT_NSPEC:    st_d.nspec    = 1'b1;
                ACT_UNCACHED: st_d.uncached = 1'b1;
                ACT_TRAP:     st_d.trap     = 1'b1;
                default:      st_d.err      = 1'b1;
            endcase
        end
        if (scan_count != '0) begin
            st_d.done_seq = last_seq;
            st_d.pc       = last_npc;
        end
        if (trap_clear_i) begin
            st_d.trap_pend = 1'b0;
        end
        if (st_d.trap) begin
            st_d.trap_pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign retire_o       = st_q.retire;
    assign complete_o     = st_q.complete;
    assign count_o        = st_q.count;
    assign bw_limit_o     = st_q.bw_limit;
    assign nspec_req_o    = st_q.nspec;
    assign uncached_req_o = st_q.uncached;
    assign trap_req_o     = st_q.trap;
    assign err_o          = st_q.err;
    assign req_seq_o      = st_q.req_seq;
    assign done_seq_o     = st_q.done_seq;
    assign pc_o           = st_q.pc;
    assign trap_pend_o    = st_q.trap_pend;

endmodule

// File: rtl/rob_commit_decide_chk.sv
module rob_commit_decide_chk #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned SEQW  = 16,
    parameter int unsigned PCW   = 32
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [WIDTH-1:0]           retire_o,
    input logic [WIDTH-1:0]           complete_o,
    input logic [$clog2(WIDTH+1)-1:0] count_o,
    input logic                       bw_limit_o,
    input logic                       nspec_req_o,
    input logic                       uncached_req_o,
    input logic                       trap_req_o,
    input logic                       err_o,
    input logic [SEQW-1:0]            done_seq_o,
    input logic [PCW-1:0]             pc_o,
    input logic                       trap_pend_o
);

    p_one_request_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({nspec_req_o, uncached_req_o, trap_req_o, err_o}));

    p_prefix_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((WIDTH'(retire_o + 1'b1) & retire_o) == '0));

    p_count_le_retire_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(count_o) <= $countones(retire_o)));

    p_nspec_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nspec_req_o |-> (count_o == '0));

    p_trap_lead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> ((count_o == '0) && trap_pend_o));

    p_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_pend_o |=> ((retire_o == '0) && (count_o == '0)));

    p_hold_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == '0) |-> ($stable(done_seq_o) && $stable(pc_o)));

    p_complete_sub_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((complete_o & ~retire_o) == '0));

    p_full_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bw_limit_o |-> (&retire_o));

endmodule

bind rob_commit_decide rob_commit_decide_chk #(
    .WIDTH (WIDTH),
    .SEQW  (SEQW),
    .PCW   (PCW)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .retire_o       (retire_o),
    .complete_o     (complete_o),
    .count_o        (count_o),
    .bw_limit_o     (bw_limit_o),
    .nspec_req_o    (nspec_req_o),
    .uncached_req_o (uncached_req_o),
    .trap_req_o     (trap_req_o),
    .err_o          (err_o),
    .done_seq_o     (done_seq_o),
    .pc_o           (pc_o),
    .trap_pend_o    (trap_pend_o)
);

// File: tb/rob_commit_decide_tb.sv
module rob_commit_decide_tb;

    localparam int unsigned W    = 4;
    localparam int unsigned SEQW = 16;
    localparam int unsigned PCW  = 32;

    // Attribute bits (R1 layout)
    localparam logic [9:0] EX = 10'h001;
    localparam logic [9:0] SQ = 10'h002;
    localparam logic [9:0] NS = 10'h004;
    localparam logic [9:0] SC = 10'h008;
    localparam logic [9:0] MB = 10'h010;
    localparam logic [9:0] QU = 10'h040;
    localparam logic [9:0] LD = 10'h080;
    localparam logic [9:0] ST = 10'h100;
    localparam logic [9:0] FT = 10'h200;

    // kind: 0 none, 1 non-spec, 2 uncached, 3 trap, 4 error
    typedef struct packed {
        logic       sp;
        logic [3:0] vld;
        logic [9:0] f0;
        logic [9:0] f1;
        logic [9:0] f2;
        logic [9:0] f3;
        logic [3:0] ret;
        logic [3:0] cmp;
        logic [2:0] cnt;
        logic [2:0] kind;
        logic [1:0] ks;
        logic [1:0] last;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{1'b0, 4'b1111, EX, EX, EX, EX,        4'b1111, 4'b1111, 3'd4, 3'd0, 2'd0, 2'd3},
        '{1'b0, 4'b1011, EX, EX, 10'h0, EX,     4'b0011, 4'b0011, 3'd2, 3'd0, 2'd0, 2'd1},
        '{1'b0, 4'b1111, SQ, EX, SQ, EX,        4'b1111, 4'b1010, 3'd2, 3'd0, 2'd0, 2'd3},
        '{1'b1, 4'b0001, NS, 10'h0, 10'h0, 10'h0, 4'b0000, 4'b0000, 3'd0, 3'd1, 2'd0, 2'd0},
        '{1'b1, 4'b0001, MB, 10'h0, 10'h0, 10'h0, 4'b0000, 4'b0000, 3'd0, 3'd0, 2'd0, 2'd0},
        '{1'b0, 4'b0001, MB, 10'h0, 10'h0, 10'h0, 4'b0000, 4'b0000, 3'd0, 3'd1, 2'd0, 2'd0},
        '{1'b0, 4'b0011, EX, NS, 10'h0, 10'h0,  4'b0001, 4'b0001, 3'd1, 3'd0, 2'd0, 2'd0},
        '{1'b0, 4'b0011, SQ, NS|QU, 10'h0, 10'h0, 4'b0001, 4'b0000, 3'd0, 3'd1, 2'd1, 2'd0},
        '{1'b1, 4'b0011, SQ, NS|QU, 10'h0, 10'h0, 4'b0001, 4'b0000, 3'd0, 3'd0, 2'd0, 2'd0},
        '{1'b0, 4'b0011, EX, LD, 10'h0, 10'h0,  4'b0001, 4'b0001, 3'd1, 3'd2, 2'd1, 2'd0},
        '{1'b1, 4'b0001, EX|FT, 10'h0, 10'h0, 10'h0, 4'b0000, 4'b0000, 3'd0, 3'd0, 2'd0, 2'd0},
        '{1'b0, 4'b0011, EX, EX|FT, 10'h0, 10'h0, 4'b0001, 4'b0001, 3'd1, 3'd0, 2'd0, 2'd0},
        '{1'b0, 4'b0011, EX, 10'h0, 10'h0, 10'h0, 4'b0001, 4'b0001, 3'd1, 3'd4, 2'd1, 2'd0},
        '{1'b0, 4'b0111, EX|ST, EX, EX|ST, 10'h0, 4'b0111, 4'b0010, 3'd3, 3'd0, 2'd0, 2'd2},
        '{1'b1, 4'b0001, SC, 10'h0, 10'h0, 10'h0, 4'b0000, 4'b0000, 3'd0, 3'd1, 2'd0, 2'd0}
    };

    logic                clk_i = 1'b0;
    logic                rst_ni = 1'b0;
    logic                stores_pend_i = 1'b0;
    logic                trap_clear_i = 1'b0;
    logic [W-1:0]        head_vld_i = '0;
    logic [W*10-1:0]     head_flags_i = '0;
    logic [W*SEQW-1:0]   head_seq_i = '0;
    logic [W*PCW-1:0]    head_npc_i = '0;
    logic [W-1:0]        retire_o;
    logic [W-1:0]        complete_o;
    logic [2:0]          count_o;
    logic                bw_limit_o;
    logic                nspec_req_o;
    logic                uncached_req_o;
    logic                trap_req_o;
    logic                err_o;
    logic [SEQW-1:0]     req_seq_o;
    logic [SEQW-1:0]     done_seq_o;
    logic [PCW-1:0]      pc_o;
    logic                trap_pend_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [SEQW-1:0] exp_done = '0;
    logic [PCW-1:0]  exp_pc = '0;

    always #2 clk_i = ~clk_i;

    rob_commit_decide #(.WIDTH(W), .SEQW(SEQW), .PCW(PCW)) u_dut (
        .clk_i, .rst_ni, .stores_pend_i, .trap_clear_i,
        .head_vld_i, .head_flags_i, .head_seq_i, .head_npc_i,
        .retire_o, .complete_o, .count_o, .bw_limit_o,
        .nspec_req_o, .uncached_req_o, .trap_req_o, .err_o,
        .req_seq_o, .done_seq_o, .pc_o, .trap_pend_o
    );

    function automatic logic [SEQW-1:0] seqf(input int k, input int s);
        return SEQW'(k * 8 + s + 1);
    endfunction

    function automatic logic [PCW-1:0] npcf(input int k, input int s);
        return PCW'(32'h1000 + k * 64 + s * 4);
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic drive(input int k, input logic sp, input logic [3:0] vld,
                         input logic [9:0] f0, input logic [9:0] f1,
                         input logic [9:0] f2, input logic [9:0] f3);
        stores_pend_i = sp;
        head_vld_i    = vld;
        head_flags_i  = {f3, f2, f1, f0};
        for (int s = 0; s < W; s++) begin
            head_seq_i[s*SEQW +: SEQW] = seqf(k, s);
            head_npc_i[s*PCW +: PCW]   = npcf(k, s);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R11 reset state
        check("R11 retire", 64'(retire_o), 64'h0);
        check("R11 count", 64'(count_o), 64'h0);
        check("R11 requests", 64'({nspec_req_o, uncached_req_o, trap_req_o, err_o, bw_limit_o}), 64'h0);
        check("R11 position", 64'({done_seq_o, pc_o}), 64'h0);
        check("R11 trap pending", 64'(trap_pend_o), 64'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R12: output changes only after the clock edge
        drive(30, 1'b0, 4'b1111, EX, EX, EX, EX);
        #1;
        check("R12 before edge", 64'(retire_o), 64'h0);
        @(negedge clk_i);
        check("R12 after edge", 64'(retire_o), 64'hF);
        exp_done = seqf(30, 3);
        exp_pc   = npcf(30, 3);

        for (int k = 0; k < NV; k++) begin
            drive(k, VT[k].sp, VT[k].vld, VT[k].f0, VT[k].f1, VT[k].f2, VT[k].f3);
            @(negedge clk_i);
            if (VT[k].cnt != 3'd0) begin
                exp_done = seqf(k, int'(VT[k].last));
                exp_pc   = npcf(k, int'(VT[k].last));
            end
            $display("vector %0d", k);
            check("R1 R2 retire mask", 64'(retire_o), 64'(VT[k].ret));
            check("R8 complete mask", 64'(complete_o), 64'(VT[k].cmp));
            check("R2 count", 64'(count_o), 64'(VT[k].cnt));
            check("R9 bandwidth limit", 64'(bw_limit_o), 64'(VT[k].cnt == 3'd4));
            check("R3 nspec", 64'(nspec_req_o), 64'(VT[k].kind == 3'd1));
            check("R4 uncached", 64'(uncached_req_o), 64'(VT[k].kind == 3'd2));
            check("R5 trap", 64'(trap_req_o), 64'(VT[k].kind == 3'd3));
            check("R10 error", 64'(err_o), 64'(VT[k].kind == 3'd4));
            if (VT[k].kind != 3'd0) begin
                check("R3 R4 R10 request seq", 64'(req_seq_o), 64'(seqf(k, int'(VT[k].ks))));
            end
            check("R7 done seq", 64'(done_seq_o), 64'(exp_done));
            check("R7 pc", 64'(pc_o), 64'(exp_pc));
        end

        // R5: squashed slot 0, fault in slot 1 at commit position zero
        drive(20, 1'b0, 4'b0011, SQ, EX|FT, 10'h0, 10'h0);
        @(negedge clk_i);
        check("R5 retire", 64'(retire_o), 64'h1);
        check("R5 trap req", 64'(trap_req_o), 64'h1);
        check("R5 trap seq", 64'(req_seq_o), 64'(seqf(20, 1)));
        check("R5 trap pending", 64'(trap_pend_o), 64'h1);

        // R6: blocked while pending
        drive(21, 1'b0, 4'b1111, EX, EX, EX, EX);
        @(negedge clk_i);
        check("R6 blocked retire", 64'(retire_o), 64'h0);
        check("R6 still pending", 64'(trap_pend_o), 64'h1);
        check("R7 held done seq", 64'(done_seq_o), 64'(exp_done));

        trap_clear_i = 1'b1;
        drive(22, 1'b0, 4'b1111, EX, EX, EX, EX);
        @(negedge clk_i);
        trap_clear_i = 1'b0;
        check("R6 release cycle retire", 64'(retire_o), 64'h0);
        check("R6 released", 64'(trap_pend_o), 64'h0);

        drive(23, 1'b0, 4'b1111, EX, EX, EX, EX);
        @(negedge clk_i);
        check("R6 resumed retire", 64'(retire_o), 64'hF);
        check("R7 resumed done seq", 64'(done_seq_o), 64'(seqf(23, 3)));
        check("R7 resumed pc", 64'(pc_o), 64'(npcf(23, 3)));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule